// File: doc/BRIEF.md
# Global Counter with Step-Rearming Comparator

This block is a memory-mapped timer built around a 64-bit up-counter and a single 64-bit match value. Software loads the counter through two 32-bit halves, starts it through a control word, and arms the comparator. When the running count equals the match value, a sticky event flag is raised. The flag drives the interrupt line while its enable bit is set. With step mode selected, every match adds a programmed 32-bit step to the match value, so the events repeat at a fixed period without software reloading anything.

Writes to the counter halves, the match halves, the step and the control word do not land at once. Each one is held in a pending slot for a parameterised number of cycles (WRITE_LATENCY, default 4). It is then applied, and a sticky settle flag reports that it landed. Software clears a settle flag by writing 1 to its bit. A second write to the same register while the first is still pending replaces the held value and restarts the wait. Each pending slot is a two-state machine. SLOT_IDLE moves to SLOT_HOLD on a write. SLOT_HOLD stays in SLOT_HOLD on a rewrite or while its countdown is non-zero, and it returns to SLOT_IDLE in the cycle that applies the value. The event flag, event enable and settle-flag registers act at once.

Top module: `gtimer_top`

## Requirements
- R1: After reset the counter reads 0 and is stopped, the comparator is off, every register in the map reads 0 and irq is 0.
- R2: Address map (byte offsets): count low 0x100, count high 0x104, count settle flags 0x110, match low 0x200, match high 0x204, step 0x208, control 0x240, event flag 0x244, event enable 0x248, register settle flags 0x24C. Any other address reads 0.
- R3: A write to count low/high, match low/high, step or control is applied WRITE_LATENCY clock edges after the edge that captured it. Until then the old value reads back. At the applying edge its settle flag is set. The flags are bit 0 of 0x110 for count low, bit 1 of 0x110 for count high, bit 0 of 0x24C for match low, bit 1 of 0x24C for match high, bit 2 of 0x24C for step, and bit 16 of 0x24C for control.
- R4: A second write to a register whose earlier write is still pending replaces the pending value and restarts the wait. The earlier value is never applied and the flag stays clear until the later write lands.
- R5: Writing 1 to a settle-flag bit clears it. Writing 0 leaves it unchanged.
- R6: With control bit 8 set the counter rises by exactly 1 per cycle. With it clear the counter holds.
- R7: Applying a count-low or count-high write replaces only that half. A carry out of the low half reaches the high half in the same cycle, so both halves read together are always consistent.
- R8: With control bit 0 set, the cycle in which the count equals the 64-bit match value sets event flag bit 0 at the next edge. With control bit 0 clear the flag is never set.
- R9: With control bits 0 and 1 set, each match adds the step to the match value at the following edge, so events repeat every step cycles.
- R10: irq is event flag bit 0 AND event enable bit 0. Writing 1 to event flag bit 0 clears it, and event enable takes effect at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume the bus carries at most one write per cycle, and that reset is held for at least one clock edge. The counter-step and auto-rearm properties also assume software does not land a load of the same register in the same cycle. Loads are therefore excluded in the property antecedents. The bench drives every write from the falling edge with a single strobe. It issues counter and match loads only while the counter is stopped or the comparator is off, and it picks random step and match values inside the 32-bit field so that the computed periods stay within the run.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;
    localparam int unsigned DW     = 32;
    localparam int unsigned AW     = 12;
    localparam int unsigned CNT_W  = 2 * DW;
    localparam int unsigned NSLOT  = 6;

    localparam logic [AW-1:0] A_CNT_LO = 12'h100;
    localparam logic [AW-1:0] A_CNT_HI = 12'h104;
    localparam logic [AW-1:0] A_CNT_WS = 12'h110;
    localparam logic [AW-1:0] A_CMP_LO = 12'h200;
    localparam logic [AW-1:0] A_CMP_HI = 12'h204;
    localparam logic [AW-1:0] A_STEP   = 12'h208;
    localparam logic [AW-1:0] A_CTRL   = 12'h240;
    localparam logic [AW-1:0] A_EVT    = 12'h244;
    localparam logic [AW-1:0] A_IEN    = 12'h248;
    localparam logic [AW-1:0] A_REG_WS = 12'h24C;

    // slot order used for pending writes and settle flags
    localparam int unsigned S_CNT_LO = 0;
    localparam int unsigned S_CNT_HI = 1;
    localparam int unsigned S_CMP_LO = 2;
    localparam int unsigned S_CMP_HI = 3;
    localparam int unsigned S_STEP   = 4;
    localparam int unsigned S_CTRL   = 5;

    localparam int unsigned C_CMP_EN = 0;
    localparam int unsigned C_AUTO   = 1;
    localparam int unsigned C_RUN    = 8;

    localparam int unsigned WS_CTRL_BIT = 16;

    function automatic logic [AW-1:0] slot_addr(input int unsigned s);
        case (s)
            S_CNT_LO: slot_addr = A_CNT_LO;
            S_CNT_HI: slot_addr = A_CNT_HI;
            S_CMP_LO: slot_addr = A_CMP_LO;
            S_CMP_HI: slot_addr = A_CMP_HI;
            S_STEP:   slot_addr = A_STEP;
            default:  slot_addr = A_CTRL;
        endcase
    endfunction
endpackage

// File: rtl/gtimer_wslot.sv
module gtimer_wslot #(
    parameter int unsigned W   = 32,
    parameter int unsigned LAT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         apply,
    output logic [W-1:0] value
);
    localparam int unsigned CW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(LAT - 1);

    typedef enum logic {SLOT_IDLE, SLOT_HOLD} slot_e;

    slot_e         state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  hold_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: if (wr) state_d = SLOT_HOLD;
            SLOT_HOLD: begin
                if (wr)               state_d = SLOT_HOLD;
                else if (cnt_q == '0) state_d = SLOT_IDLE;
                else                  state_d = SLOT_HOLD;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            cnt_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (wr) begin
                cnt_q  <= RELOAD;
                hold_q <= wdata;
            end else if (state_q == SLOT_HOLD && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        apply = 1'b0;
        unique case (state_q)
            SLOT_IDLE: apply = 1'b0;
            SLOT_HOLD: apply = (cnt_q == '0) && !wr;
        endcase
        value = hold_q;
    end
endmodule

// File: rtl/gtimer_flags.sv
module gtimer_flags #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/gtimer_core.sv
module gtimer_core
    import gtimer_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSLOT-1:0]          apply,
    input  logic [NSLOT-1:0][DW-1:0]  sval,
    input  logic                      evt_clr,
    input  logic                      ien_we,
    input  logic                      ien_val,
    output logic [CNT_W-1:0]          count,
    output logic [CNT_W-1:0]          cmp,
    output logic [DW-1:0]             step,
    output logic [DW-1:0]             ctrl,
    output logic                      match,
    output logic                      evt,
    output logic                      inten
);
    assign match = ctrl[C_CMP_EN] && (count == cmp);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (apply[S_CNT_LO]) begin
            count <= {count[CNT_W-1:DW], sval[S_CNT_LO]};
        end else if (apply[S_CNT_HI]) begin
            count <= {sval[S_CNT_HI], count[DW-1:0]};
        end else if (ctrl[C_RUN]) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp <= '0;
        end else if (apply[S_CMP_LO]) begin
            cmp <= {cmp[CNT_W-1:DW], sval[S_CMP_LO]};
        end else if (apply[S_CMP_HI]) begin
            cmp <= {sval[S_CMP_HI], cmp[DW-1:0]};
        end else if (match && ctrl[C_AUTO]) begin
            cmp <= cmp + {{(CNT_W-DW){1'b0}}, step};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step  <= '0;
            ctrl  <= '0;
            evt   <= 1'b0;
            inten <= 1'b0;
        end else begin
            if (apply[S_STEP]) step <= sval[S_STEP];
            if (apply[S_CTRL]) ctrl <= sval[S_CTRL];
            if (match)         evt  <= 1'b1;
            else if (evt_clr)  evt  <= 1'b0;
            if (ien_we)        inten <= ien_val;
        end
    end
endmodule

// File: rtl/gtimer_rdmux.sv
module gtimer_rdmux
    import gtimer_pkg::*;
(
    input  logic [AW-1:0]    addr,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    input  logic [DW-1:0]    step,
    input  logic [DW-1:0]    ctrl,
    input  logic             evt,
    input  logic             inten,
    input  logic [NSLOT-1:0] flags,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] cnt_ws, reg_ws;

    always_comb begin
        cnt_ws = '0;
        cnt_ws[0] = flags[S_CNT_LO];
        cnt_ws[1] = flags[S_CNT_HI];
        reg_ws = '0;
        reg_ws[0] = flags[S_CMP_LO];
        reg_ws[1] = flags[S_CMP_HI];
        reg_ws[2] = flags[S_STEP];
        reg_ws[WS_CTRL_BIT] = flags[S_CTRL];
    end

    always_comb begin
        unique case (addr)
            A_CNT_LO: rdata = count[DW-1:0];
            A_CNT_HI: rdata = count[CNT_W-1:DW];
            A_CNT_WS: rdata = cnt_ws;
            A_CMP_LO: rdata = cmp[DW-1:0];
            A_CMP_HI: rdata = cmp[CNT_W-1:DW];
            A_STEP:   rdata = step;
            A_CTRL:   rdata = ctrl;
            A_EVT:    rdata = {{(DW-1){1'b0}}, evt};
            A_IEN:    rdata = {{(DW-1){1'b0}}, inten};
            A_REG_WS: rdata = reg_ws;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gtimer_top.sv
module gtimer_top
    import gtimer_pkg::*;
#(
    parameter int unsigned WRITE_LATENCY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [11:0]   bus_addr,
    input  logic [31:0]   bus_wdata,
    input  logic          bus_we,
    output logic [31:0]   bus_rdata,
    output logic          irq
);
    logic [NSLOT-1:0]         slot_wr, apply, flag_clr, flags;
    logic [NSLOT-1:0][DW-1:0] slot_val;
    logic [CNT_W-1:0]         count, cmp_val;
    logic [DW-1:0]            step_val, ctrl_q;
    logic                     match, evt, inten;
    logic                     cws_wr, rws_wr, evt_clr, ien_we;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign slot_wr[s] = bus_we && (bus_addr == slot_addr(s));
        gtimer_wslot #(.W(DW), .LAT(WRITE_LATENCY)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (slot_wr[s]),
            .wdata (bus_wdata),
            .apply (apply[s]),
            .value (slot_val[s])
        );
    end

    assign cws_wr  = bus_we && (bus_addr == A_CNT_WS);
    assign rws_wr  = bus_we && (bus_addr == A_REG_WS);
    assign evt_clr = bus_we && (bus_addr == A_EVT) && bus_wdata[0];
    assign ien_we  = bus_we && (bus_addr == A_IEN);

    always_comb begin
        flag_clr           = '0;
        flag_clr[S_CNT_LO] = cws_wr && bus_wdata[0];
        flag_clr[S_CNT_HI] = cws_wr && bus_wdata[1];
        flag_clr[S_CMP_LO] = rws_wr && bus_wdata[0];
        flag_clr[S_CMP_HI] = rws_wr && bus_wdata[1];
        flag_clr[S_STEP]   = rws_wr && bus_wdata[2];
        flag_clr[S_CTRL]   = rws_wr && bus_wdata[WS_CTRL_BIT];
    end

    gtimer_flags #(.N(NSLOT)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (apply),
        .clr   (flag_clr),
        .flags (flags)
    );

    gtimer_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .apply   (apply),
        .sval    (slot_val),
        .evt_clr (evt_clr),
        .ien_we  (ien_we),
        .ien_val (bus_wdata[0]),
        .count   (count),
        .cmp     (cmp_val),
        .step    (step_val),
        .ctrl    (ctrl_q),
        .match   (match),
        .evt     (evt),
        .inten   (inten)
    );

    gtimer_rdmux u_rd (
        .addr  (bus_addr),
        .count (count),
        .cmp   (cmp_val),
        .step  (step_val),
        .ctrl  (ctrl_q),
        .evt   (evt),
        .inten (inten),
        .flags (flags),
        .rdata (bus_rdata)
    );

    assign irq = evt && inten;
endmodule

// File: rtl/gtimer_chk.sv
module gtimer_chk
    import gtimer_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cmp_val,
    input logic [DW-1:0]    step_val,
    input logic [DW-1:0]    ctrl_q,
    input logic             match,
    input logic             evt,
    input logic [NSLOT-1:0] apply,
    input logic [NSLOT-1:0] flags,
    input logic             irq
);
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[C_RUN] && !apply[S_CNT_LO] && !apply[S_CNT_HI])
        |=> count == $past(count) + 64'd1);

    assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[C_RUN] && !apply[S_CNT_LO] && !apply[S_CNT_HI])
        |=> $stable(count));

    assert_match_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> evt);

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !match) |=> !evt);

    assert_autoinc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (match && ctrl_q[C_AUTO] && !apply[S_CMP_LO] && !apply[S_CMP_HI])
        |=> cmp_val == $past(cmp_val) + {32'd0, $past(step_val)});

    assert_irq_needs_evt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> evt);

    for (genvar i = 0; i < NSLOT; i++) begin : g_fl
        assert_flag_only_on_apply_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!flags[i] && !apply[i]) |=> !flags[i]);
    end
endmodule

bind gtimer_top gtimer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (count),
    .cmp_val  (cmp_val),
    .step_val (step_val),
    .ctrl_q   (ctrl_q),
    .match    (match),
    .evt      (evt),
    .apply    (apply),
    .flags    (flags),
    .irq      (irq)
);

// File: tb/gtimer_top_test.sv
`timescale 1ns/1ps
module gtimer_top_test;
    localparam int LAT = 4;
    localparam logic [11:0] A_CLO = 12'h100, A_CHI = 12'h104, A_CWS = 12'h110,
                            A_MLO = 12'h200, A_MHI = 12'h204, A_STP = 12'h208,
                            A_CTL = 12'h240, A_EVT = 12'h244, A_IEN = 12'h248,
                            A_RWS = 12'h24C;
    localparam logic [31:0] RUN = 32'h100, CEN = 32'h1, AUTO = 32'h2;

    logic clk = 0, rst_n = 0, bus_we = 0, irq;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    int nvec = 0, nbad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gtimer_top uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq));

    function automatic logic [63:0] cmp_after(input logic [63:0] base, input logic [31:0] stp, input int n);
        return base + 64'(n) * {32'd0, stp};
    endfunction

    function automatic logic [31:0] flag_mask(input logic [11:0] a);
        case (a)
            A_MLO: return 32'h1;
            A_MHI: return 32'h2;
            A_STP: return 32'h4;
            default: return 32'h1_0000;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_settle(input logic [11:0] a, input logic [31:0] d);
        wr(a, d); waitn(LAT);
    endtask

    task automatic clear_all;
        wr(A_CWS, 32'h3); wr(A_RWS, 32'h1_0007);
    endtask

    initial begin
        #(150_000 * 5);
        nvec++; nbad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [31:0] v, a, b, stp;
        logic [11:0] addrs [10];
        void'($urandom(32'h5EED_0042));
        addrs = '{A_CLO, A_CHI, A_CWS, A_MLO, A_MHI, A_STP, A_CTL, A_EVT, A_IEN, A_RWS};
        waitn(5);
        rst_n = 1;
        waitn(1);

        // R1 reset state, R2 map
        foreach (addrs[i]) begin rd(addrs[i], v); check("R1 reset read", v, 0); end
        check("R1 irq", irq, 0);
        rd(12'h0F0, v); check("R2 unmapped read", v, 0);

        // R3 directed delay
        wr(A_MLO, 32'h1234);
        rd(A_MLO, v); check("R3 old value", v, 0);
        waitn(LAT-1);
        rd(A_MLO, v); check("R3 still old", v, 0);
        rd(A_RWS, v); check("R3 flag not yet", v, 0);
        waitn(1);
        rd(A_MLO, v); check("R3 applied", v, 32'h1234);
        rd(A_RWS, v); check("R3 flag set", v, 1);

        // R5 write-1-to-clear
        wr(A_RWS, 0); rd(A_RWS, v); check("R5 zero write keeps", v, 1);
        wr(A_RWS, 1); rd(A_RWS, v); check("R5 one write clears", v, 0);

        // R4 rewrite during window
        wr(A_MHI, 32'hA);
        waitn(1);
        wr(A_MHI, 32'hB);
        waitn(LAT-2);
        rd(A_MHI, v); check("R4 first not applied", v, 0);
        rd(A_RWS, v); check("R4 flag clear", v, 0);
        waitn(2);
        rd(A_MHI, v); check("R4 second applied", v, 32'hB);
        rd(A_RWS, v); check("R4 flag set", v, 2);
        clear_all();

        // R3/R5 random
        for (int it = 0; it < 16; it++) begin
            logic [11:0] ra;
            logic [31:0] old, nv;
            case ($urandom % 3)
                0: ra = A_MLO;
                1: ra = A_MHI;
                default: ra = A_STP;
            endcase
            nv = $urandom;
            rd(ra, old);
            wr(ra, nv);
            waitn(LAT-1);
            rd(ra, v); check("R3 random old", v, old);
            waitn(1);
            rd(ra, v); check("R3 random new", v, nv);
            rd(A_RWS, v); check("R3 random flag", v, flag_mask(ra));
            wr(A_RWS, flag_mask(ra));
            rd(A_RWS, v); check("R5 random clear", v, 0);
        end

        // R6 hold and run
        wr_settle(A_CLO, 32'h10);
        wr_settle(A_CHI, 0);
        rd(A_CWS, v); check("R3 count flags", v, 3);
        waitn(5);
        rd(A_CLO, v); check("R6 hold", v, 32'h10);
        wr(A_CTL, RUN); waitn(LAT+1);
        rd(A_RWS, v); check("R3 ctrl flag bit16", v, 32'h1_0000);
        rd(A_CLO, a); waitn(7); rd(A_CLO, b);
        check("R6 run rate", b - a, 7);
        clear_all();

        // R7 carry
        wr_settle(A_CTL, 0);
        wr_settle(A_CLO, 32'hFFFF_FFFE);
        wr_settle(A_CHI, 5);
        rd(A_CHI, a); rd(A_CLO, b);
        check("R7 loaded", {a, b}, 64'h5_FFFF_FFFE);
        wr(A_CTL, RUN); waitn(LAT+3);
        rd(A_CHI, a); rd(A_CLO, b);
        check("R7 carry", {a, b}, 64'h6_0000_0001);

        // R8 comparator off
        wr_settle(A_CTL, 0);
        wr_settle(A_CLO, 100); wr_settle(A_CHI, 0);
        wr_settle(A_MLO, 110); wr_settle(A_MHI, 0);
        wr(A_IEN, 1);
        wr_settle(A_CTL, RUN);
        waitn(40);
        rd(A_EVT, v); check("R8 disabled no event", v, 0);
        check("R10 no irq", irq, 0);

        // R8 match timing
        wr_settle(A_CTL, 0);
        wr_settle(A_CLO, 100);
        wr(A_CTL, RUN | CEN);
        waitn(LAT+10);
        rd(A_EVT, v); check("R8 before match", v, 0);
        waitn(1);
        rd(A_EVT, v); check("R8 match sets", v, 1);
        check("R10 irq high", irq, 1);
        wr(A_IEN, 0); check("R10 irq masked", irq, 0);
        rd(A_EVT, v); check("R10 flag kept", v, 1);
        wr(A_IEN, 1); check("R10 irq unmasked", irq, 1);
        wr(A_EVT, 1); rd(A_EVT, v); check("R10 clear", v, 0);
        check("R10 irq low", irq, 0);

        // R9 step rearm, random step
        stp = 8 + ($urandom % 24);
        wr_settle(A_CTL, 0);
        wr_settle(A_CLO, 0); wr_settle(A_CHI, 0);
        wr_settle(A_MLO, 50); wr_settle(A_MHI, 0);
        wr_settle(A_STP, stp);
        wr(A_CTL, RUN | CEN | AUTO);
        waitn(LAT+51);
        rd(A_EVT, v); check("R9 first event", v, 1);
        rd(A_MLO, v); check("R9 cmp stepped", v, cmp_after(50, stp, 1));
        for (int k = 2; k <= 4; k++) begin
            wr(A_EVT, 1);
            waitn(stp-2);
            rd(A_EVT, v); check("R9 before next", v, 0);
            waitn(1);
            rd(A_EVT, v); check("R9 periodic event", v, 1);
            rd(A_MLO, v); check("R9 cmp value", v, cmp_after(50, stp, k)[31:0]);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule